// File: doc/BRIEF.md
# Trigger Tag Capture and Holdoff Unit

This unit is the trigger-facing front of a data source. It watches a trigger strobe that arrives with no fixed relation to the local clock. It brings that strobe into the clock domain, and on each new strobe it captures a small trigger tag. Every tag waits in a short queue until the readout side starts sending the event that belongs to it. Each strobe stands for exactly one event. While a readout is starting, the oldest queued tag is written into a fixed field of the first data word, and the rest of the word passes through unchanged. Readout logic should not begin an event until `evt_ready` shows that a tag is waiting.

The unit also drives the holdoff line that throttles the trigger system. Holdoff rises when the local event buffer reaches half of its capacity. It also rises when the tag queue is full. Once a buffer overflow has been reported, holdoff stays high until reset, whatever the buffer level does afterwards. A strobe that arrives while the tag queue is full loses its tag and sets an error flag that stays set until reset.

Top module: `trig_tag_unit`

## Requirements
- R1: After reset, `evt_ready`, `holdoff` and `tag_overrun` are 0 and `hdr_word_out` equals `word_in`.
- R2: Each rising edge of the synchronized strobe queues exactly one tag, the value of `trig_tag_in` at that edge. A strobe held high for many cycles queues only one tag.
- R3: While the queue holds a tag, `hdr_word_out` is `word_in` with bits 12 to 15 replaced by the oldest tag. All other bits pass unchanged. With an empty queue, `hdr_word_out` equals `word_in`.
- R4: A cycle with `rd_start` high removes the oldest tag, so tags come out in strobe order.
- R5: `rd_start` with an empty queue is ignored: the queue stays empty and later tags are unaffected.
- R6: `evt_ready` is 1 exactly when at least one tag is queued.
- R7: A strobe that arrives while the queue holds QDEPTH tags (4 by default) is dropped. It sets `tag_overrun`, which stays 1 until reset. The queued tags are left intact.
- R8: One clock after `buf_level` is at or above BUF_CAP/2 (128 by default), `holdoff` is 1. With the level below that threshold, and neither the R9 nor the R10 condition present, `holdoff` is 0.
- R9: `holdoff` is 1 one clock after the tag queue becomes full.
- R10: Once `buf_overflow` is sampled high, `holdoff` stays 1 until reset, even after the level falls below half.
- R11: A strobe edge and `rd_start` in the same cycle, with the queue neither empty nor full, pop the oldest tag and queue the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the sticky states |
| trig_strobe | input | 1 | Trigger strobe, active high, asynchronous |
| trig_tag_in | input | 4 | Trigger tag, stable around the strobe |
| buf_level | input | 9 | Words held in the local event buffer |
| buf_overflow | input | 1 | Event buffer overflowed |
| rd_start | input | 1 | First word of an event is being sent this cycle |
| word_in | input | 32 | First data word before the tag is merged |
| hdr_word_out | output | 32 | First data word with the tag merged in |
| evt_ready | output | 1 | At least one tag is queued |
| tag_overrun | output | 1 | Sticky: a strobe was lost to a full queue |
| holdoff | output | 1 | Trigger holdoff to the trigger system |

## Verification
The assertions check several rules on every cycle. The synchronized edge is a single-cycle pulse. A strobe into a full queue raises the overrun flag on the next cycle, and that flag never falls. A pop from an empty queue leaves it empty. The merged word differs from `word_in` only inside the tag field. Holdoff follows one clock after a high level or an overflow, and once the sticky state is set it never drops. Tag values and their order through the queue, the rule that a long strobe queues only one tag, the push and pop in the same cycle, and the clearing of every sticky state by reset can only be shown by the bench scenarios, which compare against a reference queue.

// File: rtl/trig_pkg.sv
package trig_pkg;
  parameter int TAG_W_DEF   = 4;
  parameter int TAG_LSB_DEF = 12;

  // true when the buffer level has reached half of its capacity
  function automatic logic lvl_at_half(int unsigned level, int unsigned cap);
    return (level * 2) >= cap;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_rise
);
  logic [1:0] sync_q;
  logic       last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], strobe_async};
      last_q <= sync_q[1];
    end
  end

  assign strobe_rise = sync_q[1] & ~last_q;

  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);
endmodule

// File: rtl/tag_queue.sv
module tag_queue #(
  parameter int TAG_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             pop_req,
  output logic [TAG_W-1:0] head_tag,
  output logic             not_empty,
  output logic             full,
  output logic             overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             overrun_q;
  logic             push_ok, pop_ok, push_drop;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full      = (32'(count) == DEPTH);
  assign not_empty = (count != '0);
  assign push_ok   = push_req & ~full;
  assign push_drop = push_req & full;
  assign pop_ok    = pop_req & not_empty;
  assign head_tag  = mem[rd_ptr];
  assign overrun   = overrun_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= tag_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_drop) overrun_q <= 1'b1;
    end
  end

  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> overrun);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_empty_pop_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !not_empty && !push_req) |=> !not_empty);
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
endmodule

// File: rtl/holdoff_ctl.sv
module holdoff_ctl #(
  parameter int LVL_W   = 9,
  parameter int BUF_CAP = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             ovf_in,
  input  logic             queue_full,
  output logic             holdoff
);
  logic sticky_q, holdoff_q, level_high;

  assign level_high = trig_pkg::lvl_at_half(32'(level), BUF_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q  <= 1'b0;
      holdoff_q <= 1'b0;
    end else begin
      if (ovf_in) sticky_q <= 1'b1;
      holdoff_q <= sticky_q | ovf_in | queue_full | level_high;
    end
  end

  assign holdoff = holdoff_q;

  assert_level_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level_high |=> holdoff);
  assert_full_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |=> holdoff);
  assert_ovf_holdoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_in |=> holdoff);
  assert_sticky_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q |=> (sticky_q && holdoff));
endmodule

// File: rtl/trig_tag_unit.sv
module trig_tag_unit #(
  parameter int WORD_W  = 32,
  parameter int TAG_W   = trig_pkg::TAG_W_DEF,
  parameter int TAG_LSB = trig_pkg::TAG_LSB_DEF,
  parameter int QDEPTH  = 4,
  parameter int LVL_W   = 9,
  parameter int BUF_CAP = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_strobe,
  input  logic [TAG_W-1:0]  trig_tag_in,
  input  logic [LVL_W-1:0]  buf_level,
  input  logic              buf_overflow,
  input  logic              rd_start,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] hdr_word_out,
  output logic              evt_ready,
  output logic              tag_overrun,
  output logic              holdoff
);
  localparam logic [WORD_W-1:0] FIELD_MASK = ((WORD_W'(1) << TAG_W) - 1) << TAG_LSB;

  logic             strobe_rise;
  logic [TAG_W-1:0] head_tag;
  logic             q_full;

  function automatic logic [WORD_W-1:0] put_tag(logic [WORD_W-1:0] w, logic [TAG_W-1:0] t);
    logic [WORD_W-1:0] r;
    r = w;
    r[TAG_LSB +: TAG_W] = t;
    return r;
  endfunction

  strobe_sync u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_async(trig_strobe), .strobe_rise(strobe_rise)
  );

  tag_queue #(.TAG_W(TAG_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_req(strobe_rise), .tag_in(trig_tag_in),
    .pop_req(rd_start), .head_tag(head_tag), .not_empty(evt_ready),
    .full(q_full), .overrun(tag_overrun)
  );

  holdoff_ctl #(.LVL_W(LVL_W), .BUF_CAP(BUF_CAP)) u_hold (
    .clk(clk), .rst_n(rst_n), .level(buf_level), .ovf_in(buf_overflow),
    .queue_full(q_full), .holdoff(holdoff)
  );

  assign hdr_word_out = evt_ready ? put_tag(word_in, head_tag) : word_in;

  assert_merge_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hdr_word_out ^ word_in) & ~FIELD_MASK) == '0);
  assert_empty_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |-> (hdr_word_out == word_in));
endmodule

// File: tb/test_trig_tag_unit.sv
`timescale 1ns/1ps
module test_trig_tag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_strobe = 1'b0;
  logic [3:0]  trig_tag_in = '0;
  logic [8:0]  buf_level = '0;
  logic        buf_overflow = 1'b0;
  logic        rd_start = 1'b0;
  logic [31:0] word_in = '0;
  logic [31:0] hdr_word_out;
  logic        evt_ready, tag_overrun, holdoff;

  int total = 0;
  int bad = 0;
  int mq[$];
  bit sticky_m = 0;
  bit err_m = 0;

  always #2.5 clk = ~clk;

  trig_tag_unit i_trig_tag_unit (
    .clk(clk), .rst_n(rst_n), .trig_strobe(trig_strobe), .trig_tag_in(trig_tag_in),
    .buf_level(buf_level), .buf_overflow(buf_overflow), .rd_start(rd_start),
    .word_in(word_in), .hdr_word_out(hdr_word_out), .evt_ready(evt_ready),
    .tag_overrun(tag_overrun), .holdoff(holdoff)
  );

  function automatic logic [31:0] exp_word(logic [31:0] w);
    if (mq.size() == 0) return w;
    return (w & 32'hFFFF_0FFF) | (32'(mq[0]) * 32'h1000);
  endfunction

  function automatic bit exp_hold();
    return sticky_m || (int'(buf_level) >= 128) || (mq.size() == 4);
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    @(negedge clk);
    chk(32'(evt_ready), 32'(mq.size() != 0), {req, " R6 evt_ready"});
    chk(32'(tag_overrun), 32'(err_m), {req, " R7 overrun"});
    chk(32'(holdoff), 32'(exp_hold()), {req, " R8 R9 R10 holdoff"});
  endtask

  task automatic do_strobe(logic [3:0] t, int hold_cycles);
    @(negedge clk);
    trig_strobe = 1'b1;
    trig_tag_in = t;
    repeat (hold_cycles) @(negedge clk);
    trig_strobe = 1'b0;
    repeat (3) @(negedge clk);
    trig_tag_in = ~t;
    if (mq.size() < 4) mq.push_back(int'(t));
    else err_m = 1;
  endtask

  task automatic do_read(logic [31:0] w, string req);
    @(negedge clk);
    word_in = w;
    rd_start = 1'b1;
    #1 chk(hdr_word_out, exp_word(w), req);
    @(negedge clk);
    rd_start = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    buf_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mq.delete();
    sticky_m = 0;
    err_m = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    word_in = 32'hDEAD_BEEF;
    #1;
    chk(32'(evt_ready), 0, "R1 evt_ready in reset");
    chk(32'(holdoff), 0, "R1 holdoff in reset");
    chk(32'(tag_overrun), 0, "R1 overrun in reset");
    chk(hdr_word_out, 32'hDEAD_BEEF, "R1 word passes in reset");
    rst_n = 1'b1;

    // R5: pop on empty queue is ignored
    do_read(32'h1234_5678, "R5 R3 empty read passes word");
    check_state("R5");
    // R2: long strobe queues a single tag
    do_strobe(4'hA, 14);
    check_state("R2 long strobe");
    chk(32'(mq.size()), 1, "R2 single entry in model");
    do_read(32'hFFFF_FFFF, "R2 R3 tag A merged");
    check_state("R4 after pop");

    // R7 R9: fill, overrun, drain in order (R4)
    for (int i = 0; i < 5; i++) do_strobe(4'(i + 3), 4);
    check_state("R7 R9 full queue");
    for (int i = 0; i < 4; i++) do_read(32'h0000_0000, "R4 ordered drain");
    check_state("R4 drained");
    do_reset();
    check_state("R1 after reset");

    // R11: push and pop in the same cycle
    do_strobe(4'h1, 4);
    do_strobe(4'h2, 4);
    @(negedge clk);
    trig_strobe = 1'b1;
    trig_tag_in = 4'h9;
    @(negedge clk);
    @(negedge clk);
    word_in = 32'h0F0F_F0F0;
    rd_start = 1'b1;
    #1 chk(hdr_word_out, exp_word(32'h0F0F_F0F0), "R11 head during same-cycle pop");
    @(negedge clk);
    rd_start = 1'b0;
    void'(mq.pop_front());
    mq.push_back(9);
    repeat (2) @(negedge clk);
    trig_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R11");
    do_read(32'h0, "R11 second tag");
    do_read(32'h0, "R11 new tag last");
    check_state("R11 drained");

    // R8: threshold edges
    @(negedge clk); buf_level = 9'd127;
    check_state("R8 level 127");
    @(negedge clk); buf_level = 9'd128;
    check_state("R8 level 128");
    @(negedge clk); buf_level = 9'd5;
    check_state("R8 level back low");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int act;
      act = int'($urandom % 4);
      if (act == 0) do_strobe(4'($urandom), 3 + int'($urandom % 4));
      else if (act == 1) do_read($urandom, "R3 R4 random read");
      else begin
        @(negedge clk);
        buf_level = 9'($urandom % 257);
      end
      check_state("random");
    end

    // R10: sticky after overflow
    do_reset();
    @(negedge clk); buf_level = 9'd200;
    @(negedge clk); buf_overflow = 1'b1;
    @(negedge clk); buf_overflow = 1'b0; sticky_m = 1;
    buf_level = 9'd3;
    repeat (5) check_state("R10 sticky holdoff");
    do_reset();
    check_state("R1 R10 reset clears sticky");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule